// File: doc/BRIEF.md
# Three-Table Logic Cell with Memory Mode

This block is one configurable logic cell. Two first-level lookup tables of sixteen entries each take four address inputs apiece, and a third, eight-entry table forms a result from the two first-level outputs plus one extra input. With the third table in use the cell computes one function of up to nine inputs. Without it, the first-level outputs serve as two unrelated four-input functions. Two flip-flops register the results.

A two-bit mode input sets how the first-level tables are used. In logic mode their contents come from configuration words. In arithmetic mode a dedicated carry path feeds carries into the table addresses so that the tables produce two adder sum bits, and the cell passes the carry on to the next cell. In the two memory modes the tables become 16-by-1 storage that is written on the clock edge and read without a clock. One memory mode gives two separate single-port memories. The other gives one memory with a shared write/read address and a second, independent read address.

Top module: `clb_tri_lut`

## Requirements
- R1: Mode encoding on `mode_i`: 0 logic, 1 arithmetic, 2 single-port memory, 3 dual-port memory. In logic mode, `f_out_o` equals bit `f_in_i` of `cfg_f_i` and `g_out_o` equals bit `g_in_i` of `cfg_g_i`, both combinational. Each output depends only on its own table's inputs.
- R2: In every mode, `h_out_o` equals bit (4*`h_in_i` + 2*`g_out_o` + `f_out_o`) of `cfg_h_i`.
- R3: On each rising clock edge, `ff0_q_o` takes `h_out_o` when `ff0_sel_i` is 1 and takes `f_out_o` otherwise. `ff1_q_o` takes `g_out_o`. Both flip-flops are 0 during and directly after the active-low reset.
- R4: In arithmetic mode, address bit 2 of the F table is replaced by `cin_i`. Address bit 2 of the G table is replaced by the inner carry c1 = majority(`f_in_i[0]`, `f_in_i[1]`, `cin_i`). `cout_o` = majority(`g_in_i[0]`, `g_in_i[1]`, c1). In all other modes `cout_o` is 0.
- R5: In mode 2 with `we_i` high, a rising edge writes `wdata_i[0]` to F location `f_in_i` and `wdata_i[1]` to G location `g_in_i`. `f_out_o` reads F at `f_in_i` and `g_out_o` reads G at `g_in_i`, both combinational.
- R6: In mode 3 with `we_i` high, a rising edge writes `wdata_i[0]` at location `f_in_i` of both tables. `f_out_o` reads at `f_in_i` and `g_out_o` reads at `g_in_i`, so `g_in_i` acts as the second read address.
- R7: Reset clears both memories to 0. In modes 0 and 1, `we_i` leaves the memories unchanged. Memory contents persist across mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Cell mode (see R1) |
| cfg_f_i | input | 16 | F table contents in logic and arithmetic modes |
| cfg_g_i | input | 16 | G table contents in logic and arithmetic modes |
| cfg_h_i | input | 8 | Third-table contents |
| ff0_sel_i | input | 1 | Flip-flop 0 source: 1 third table, 0 F table |
| f_in_i | input | 4 | F table inputs / write and first read address |
| g_in_i | input | 4 | G table inputs / second read address |
| h_in_i | input | 1 | Extra input to the third table |
| cin_i | input | 1 | Carry in |
| we_i | input | 1 | Memory write enable |
| wdata_i | input | 2 | Memory write data (bit 0 F, bit 1 G) |
| f_out_o | output | 1 | F table result |
| g_out_o | output | 1 | G table result |
| h_out_o | output | 1 | Third-table result |
| ff0_q_o | output | 1 | Flip-flop 0 |
| ff1_q_o | output | 1 | Flip-flop 1 |
| cout_o | output | 1 | Carry out |

## Verification
The table outputs, the third-table result and the carry out have no clock between input and output. The bench checks them 1 ns after it drives inputs on the falling edge, in the same cycle. Memory writes and flip-flop loads take effect on the next rising edge. The bench therefore updates its model at that edge and checks the flip-flops and any read of the written location on the following falling edge, one cycle after the stimulus.

// File: rtl/clb_pkg.sv
package clb_pkg;

    typedef enum logic [1:0] {
        MODE_LOGIC  = 2'd0,
        MODE_ARITH  = 2'd1,
        MODE_RAM_SP = 2'd2,
        MODE_RAM_DP = 2'd3
    } clb_mode_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4,
    localparam int DEPTH = 1 << K
) (
    input  logic [DEPTH-1:0] table_i,
    input  logic [K-1:0]     addr_i,
    output logic             data_o
);
    assign data_o = table_i[addr_i];
endmodule

// File: rtl/clb_carry.sv
module clb_carry
    import clb_pkg::*;
(
    input  logic a0_i,
    input  logic b0_i,
    input  logic a1_i,
    input  logic b1_i,
    input  logic cin_i,
    output logic c_mid_o,
    output logic cout_o
);
    assign c_mid_o = maj3(a0_i, b0_i, cin_i);
    assign cout_o  = maj3(a1_i, b1_i, c_mid_o);

    // R4: equal operand bits generate or kill the carry regardless of carry in
    always_comb begin
        if (a0_i == b0_i) begin
            a_r4_low_gen_kill: assert (c_mid_o == a0_i);
        end
        if (a1_i == b1_i) begin
            a_r4_high_gen_kill: assert (cout_o == a1_i);
        end
        if (a0_i != b0_i) begin
            a_r4_low_propagate: assert (c_mid_o == cin_i);
        end
    end
endmodule

// File: rtl/clb_tri_lut.sv
module clb_tri_lut
    import clb_pkg::*;
#(
    parameter int K = 4,
    localparam int DEPTH = 1 << K,
    localparam int H_K = 3,
    localparam int H_DEPTH = 1 << H_K,
    localparam int CBIT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic [DEPTH-1:0]   cfg_f_i,
    input  logic [DEPTH-1:0]   cfg_g_i,
    input  logic [H_DEPTH-1:0] cfg_h_i,
    input  logic               ff0_sel_i,
    input  logic [K-1:0]       f_in_i,
    input  logic [K-1:0]       g_in_i,
    input  logic               h_in_i,
    input  logic               cin_i,
    input  logic               we_i,
    input  logic [1:0]         wdata_i,
    output logic               f_out_o,
    output logic               g_out_o,
    output logic               h_out_o,
    output logic               ff0_q_o,
    output logic               ff1_q_o,
    output logic               cout_o
);

    typedef struct packed {
        logic [DEPTH-1:0] ram_f;
        logic [DEPTH-1:0] ram_g;
        logic             ff0;
        logic             ff1;
    } cell_state_t;

    cell_state_t st_d, st_q;

    clb_mode_e mode;
    logic      is_arith;
    logic      is_ram;
    logic      c_mid;
    logic      cout_raw;

    logic [DEPTH-1:0] tab [2];
    logic [K-1:0]     addr [2];
    logic [1:0]       lo;
    logic             h_res;

    assign mode     = clb_mode_e'(mode_i);
    assign is_arith = (mode == MODE_ARITH);
    assign is_ram   = (mode == MODE_RAM_SP) || (mode == MODE_RAM_DP);

    clb_carry u_carry (
        .a0_i    (f_in_i[0]),
        .b0_i    (f_in_i[1]),
        .a1_i    (g_in_i[0]),
        .b1_i    (g_in_i[1]),
        .cin_i   (cin_i),
        .c_mid_o (c_mid),
        .cout_o  (cout_raw)
    );

    always_comb begin
        addr[0] = f_in_i;
        addr[1] = g_in_i;
        if (is_arith) begin
            addr[0][CBIT] = cin_i;
            addr[1][CBIT] = c_mid;
        end
        tab[0] = is_ram ? st_q.ram_f : cfg_f_i;
        tab[1] = is_ram ? st_q.ram_g : cfg_g_i;
    end

    for (genvar i = 0; i < 2; i++) begin : g_first
        clb_lut #(.K(K)) u_lut (
            .table_i (tab[i]),
            .addr_i  (addr[i]),
            .data_o  (lo[i])
        );
    end

    clb_lut #(.K(H_K)) u_third (
        .table_i (cfg_h_i),
        .addr_i  ({h_in_i, lo[1], lo[0]}),
        .data_o  (h_res)
    );

    always_comb begin
        st_d = st_q;
        if (we_i && (mode == MODE_RAM_SP)) begin
            st_d.ram_f[f_in_i] = wdata_i[0];
            st_d.ram_g[g_in_i] = wdata_i[1];
        end else if (we_i && (mode == MODE_RAM_DP)) begin
            st_d.ram_f[f_in_i] = wdata_i[0];
            st_d.ram_g[f_in_i] = wdata_i[0];
        end
        st_d.ff0 = ff0_sel_i ? h_res : lo[0];
        st_d.ff1 = lo[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign f_out_o = lo[0];
    assign g_out_o = lo[1];
    assign h_out_o = h_res;
    assign ff0_q_o = st_q.ff0;
    assign ff1_q_o = st_q.ff1;
    assign cout_o  = is_arith ? cout_raw : 1'b0;

    // R5: single-port write lands in both tables at their own addresses
    a_r5_sp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2 && we_i) |=>
            (st_q.ram_f[$past(f_in_i)] == $past(wdata_i[0])) &&
            (st_q.ram_g[$past(g_in_i)] == $past(wdata_i[1])));

    // R6: dual-port write mirrors one bit into both tables at the shared address
    a_r6_dp_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && we_i) |=>
            (st_q.ram_f[$past(f_in_i)] == $past(wdata_i[0])) &&
            (st_q.ram_g[$past(f_in_i)] == $past(wdata_i[0])));

    // R7: memories hold outside the memory modes
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[1] |=> $stable(st_q.ram_f) && $stable(st_q.ram_g));

    // R3: second flip-flop follows the G result one edge later
    a_r3_ff1_load: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ff1_q_o == $past(g_out_o));

    // R4: no carry leaves the cell outside arithmetic mode
    a_r4_cout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd1) |-> !cout_o);

endmodule

// File: tb/tb_clb_tri_lut.sv
module tb_clb_tri_lut;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic [15:0] cf, cg;
    logic [7:0]  ch;
    logic        sel;
    logic [3:0]  fin, gin;
    logic        hin, cin, we;
    logic [1:0]  wd;
    logic        f_o, g_o, h_o, q0, q1, co;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] mf, mg;
    logic        e0, e1;

    always #10 clk = ~clk;

    clb_tri_lut dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cfg_f_i(cf), .cfg_g_i(cg),
        .cfg_h_i(ch), .ff0_sel_i(sel), .f_in_i(fin), .g_in_i(gin), .h_in_i(hin),
        .cin_i(cin), .we_i(we), .wdata_i(wd), .f_out_o(f_o), .g_out_o(g_o),
        .h_out_o(h_o), .ff0_q_o(q0), .ff1_q_o(q1), .cout_o(co)
    );

    function automatic logic m_maj(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic string m_tag(logic [1:0] m);
        case (m)
            2'd0: return "R1";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Inputs are set at a falling edge; checks outputs, then crosses one rising edge.
    task automatic step();
        logic ar, rm, c1, ef, eg, eh, ec;
        logic [3:0] fa, ga;
        #1;
        ar = (mode == 2'd1);
        rm = mode[1];
        c1 = m_maj(fin[0], fin[1], cin);
        fa = fin;
        ga = gin;
        if (ar) begin
            fa[2] = cin;
            ga[2] = c1;
        end
        ef = rm ? mf[fa] : cf[fa];
        eg = rm ? mg[ga] : cg[ga];
        eh = ch[{hin, eg, ef}];
        ec = ar ? m_maj(gin[0], gin[1], c1) : 1'b0;
        chk(m_tag(mode), f_o, ef);
        chk(m_tag(mode), g_o, eg);
        chk("R2", h_o, eh);
        chk("R4", co, ec);
        e0 = sel ? eh : ef;
        e1 = eg;
        @(posedge clk);
        if (we && mode == 2'd2) begin
            mf[fin] = wd[0];
            mg[gin] = wd[1];
        end else if (we && mode == 2'd3) begin
            mf[fin] = wd[0];
            mg[fin] = wd[0];
        end
        @(negedge clk);
        chk("R3", q0, e0);
        chk("R3", q1, e1);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; mode = 2'd2; cf = 16'h0; cg = 16'h0; ch = 8'h0; sel = 0;
        fin = 4'd5; gin = 4'd9; hin = 0; cin = 0; we = 1; wd = 2'b11;
        mf = '0; mg = '0; e0 = 0; e1 = 0;
        repeat (3) @(negedge clk);
        // Reset state: memories cleared, flip-flops low
        chk("R7", f_o, 1'b0);
        chk("R7", g_o, 1'b0);
        chk("R3", q0, 1'b0);
        chk("R3", q1, 1'b0);
        rst_n = 1;
        we = 0;

        // Arithmetic: tables hold XOR of address bits 0..2
        for (int a = 0; a < 16; a++) begin
            cf[a] = a[0] ^ a[1] ^ a[2];
            cg[a] = a[0] ^ a[1] ^ a[2];
        end
        ch = 8'b1001_0110;
        mode = 2'd1;
        fin = 4'b0011; gin = 4'b0011; cin = 1; step();
        chk("R4", co, 1'b1);
        fin = 4'b0000; gin = 4'b0000; cin = 0; step();
        chk("R4", co, 1'b0);
        fin = 4'b0001; gin = 4'b0010; cin = 1; step();
        chk("R4", co, 1'b1);
        fin = 4'b1101; gin = 4'b0110; cin = 0; step();

        // R7: fill memory in single-port mode, attempt overwrite in logic mode
        mode = 2'd2; we = 1; wd = 2'b11;
        for (int a = 0; a < 16; a++) begin
            fin = 4'(a); gin = 4'(a); step();
        end
        mode = 2'd0; wd = 2'b00;
        for (int a = 0; a < 16; a++) begin
            fin = 4'(a); gin = 4'(15 - a); step();
        end
        mode = 2'd2; we = 0;
        for (int a = 0; a < 16; a++) begin
            fin = 4'(a); gin = 4'(a); step();
            chk("R7", f_o, 1'b1);
        end

        // R6: dual-port write then independent second read
        mode = 2'd3; we = 1; wd = 2'b00; fin = 4'd7; gin = 4'd7; step();
        we = 0; fin = 4'd3; gin = 4'd7; #1;
        chk("R6", g_o, 1'b0);
        chk("R6", f_o, 1'b1);
        step();

        // Random mix of modes and inputs
        for (int n = 0; n < 4000; n++) begin
            if (n % 50 == 0) begin
                cf = 16'($urandom); cg = 16'($urandom); ch = 8'($urandom);
            end
            mode = 2'($urandom);
            fin = 4'($urandom); gin = 4'($urandom);
            hin = 1'($urandom); cin = 1'($urandom);
            we = 1'($urandom); wd = 2'($urandom); sel = 1'($urandom);
            step();
        end

        finish_run();
    end

endmodule